// File: doc/BRIEF.md
# Register-Programmed PWM Generator with Auto-Off Countdown

This block drives one pulse-width-modulated output whose timing is counted in ticks of a fixed time base that arrives as a tick-enable strobe. A host programs the block through a byte-wide write-only port made of a write strobe, an 8-bit address and 8-bit data. The period and the high time are each 16 bits wide and are written as two bytes. The upper byte is held in a staging register. The full 16-bit value is loaded only when its lower byte arrives, so each setting changes in one step and never passes through a half-written value.

An enable register starts and stops the waveform. A 16-bit auto-off interval, counted in milliseconds derived from the tick, can clear the enable by itself after a set amount of enabled time. The all-ones value of that interval means the timer never expires. Since period and duty commit separately, the output may see a duty larger than the period for a short while. In that case it stays high for the whole period rather than misbehaving.

Top module: `pwm_autooff`

## Requirements
- R1: After reset, pwm_out is low, period, duty, enable and both staging bytes are zero, and the auto-off interval is 0xFFFF.
- R2: A write to address 0xA5 (period upper byte) or 0xA7 (duty upper byte) only stages the byte and leaves the waveform unchanged.
- R3: A write to 0xA4 loads the period as {staged upper, written byte} and restarts the tick counter at 0. A write to 0xA6 loads the duty as {staged upper, written byte} without a restart.
- R4: While enabled with a non-zero period, the counter advances by one on each tick from 0 to period-1 and then wraps to 0. pwm_out is high exactly while counter < duty (normal polarity).
- R5: When duty >= period and period is non-zero, pwm_out stays high for as long as the block is enabled.
- R6: A period of 0 or a duty of 0 holds pwm_out low. A later non-zero duty resumes the waveform without the enable being rewritten.
- R7: A write to 0xA3 sets enable from data bit 0. While enable is 0, pwm_out is low and the counter is held at 0.
- R8: With the auto-off interval at 0xFFFF, enable is never cleared by the timer.
- R9: Bytes written to 0xA1 and 0xA2 take effect at once as the upper and lower halves of the auto-off interval N. Any write to 0xA1, 0xA2 or 0xA3 reloads the countdown. Enable clears after N milliseconds of enabled time (N*TICKS_PER_MS ticks) with no intervening reload.
- R10: Writes to any address outside 0xA1 to 0xA7 have no effect on the output.
- R11: The counter and the millisecond prescaler advance only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Time-base enable, one pulse per tick |
| pwm_out | output | 1 | PWM output |

## Verification
Random phases write arbitrary bytes to the period, duty, enable and unused addresses, with short periods and the tick held high or gated at random. This checks the staging and commit behaviour and the wrap point against an independent cycle model. Directed cases cover the values the random mix may miss: duty of zero followed by a non-zero duty, duty above period, and period zero. The auto-off cases separate a countdown that runs from one that is reloaded by a later write, and compare both against the never-expire code.

// File: rtl/pwm_ao_pkg.sv
package pwm_ao_pkg;

    localparam int VW = 16;

    typedef logic [VW-1:0] word_t;

    typedef enum logic [7:0] {
        ADR_AO_HI  = 8'hA1,
        ADR_AO_LO  = 8'hA2,
        ADR_EN     = 8'hA3,
        ADR_PER_LO = 8'hA4,
        ADR_PER_HI = 8'hA5,
        ADR_DUT_LO = 8'hA6,
        ADR_DUT_HI = 8'hA7
    } reg_addr_e;

    typedef struct packed {
        logic  en;
        word_t period;
        word_t duty;
        word_t ao;
    } cfg_t;

    localparam word_t AO_NEVER = '1;

    function automatic logic is_reload_addr(input logic [7:0] a);
        return (a == ADR_AO_HI) || (a == ADR_AO_LO) || (a == ADR_EN);
    endfunction

endpackage

// File: rtl/pwm_ao_regs.sv
module pwm_ao_regs
    import pwm_ao_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       expire,
    output cfg_t       cfg,
    output logic       per_load,
    output logic       reload
);

    logic [7:0] per_hi_q;
    logic [7:0] dut_hi_q;
    logic       dut_load;

    always_comb begin
        per_load = wr_en && (wr_addr == ADR_PER_LO);
        dut_load = wr_en && (wr_addr == ADR_DUT_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{en: 1'b0, period: '0, duty: '0, ao: AO_NEVER};
            per_hi_q <= '0;
            dut_hi_q <= '0;
            reload   <= 1'b0;
        end else begin
            reload <= wr_en && is_reload_addr(wr_addr);
            if (per_load)
                cfg.period <= {per_hi_q, wr_data};
            if (dut_load)
                cfg.duty <= {dut_hi_q, wr_data};
            if (wr_en) begin
                case (wr_addr)
                    ADR_PER_HI: per_hi_q          <= wr_data;
                    ADR_DUT_HI: dut_hi_q          <= wr_data;
                    ADR_AO_HI:  cfg.ao[VW-1:8]    <= wr_data;
                    ADR_AO_LO:  cfg.ao[7:0]       <= wr_data;
                    default: ;
                endcase
            end
            if (wr_en && (wr_addr == ADR_EN))
                cfg.en <= wr_data[0];
            else if (expire)
                cfg.en <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_ao_gen.sv
module pwm_ao_gen
    import pwm_ao_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  en,
    input  logic  restart,
    input  word_t period,
    input  word_t duty,
    output word_t cnt,
    output logic  pwm_out
);

    logic at_end;

    always_comb at_end = (cnt >= period - word_t'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || !en)
            cnt <= '0;
        else if (tick && (period != '0))
            cnt <= at_end ? '0 : cnt + word_t'(1);
    end

    always_comb pwm_out = en && (period != '0) && (cnt < duty);

endmodule

// File: rtl/pwm_ao_timer.sv
module pwm_ao_timer
    import pwm_ao_pkg::*;
#(
    parameter int TICKS_PER_MS = 8000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  en,
    input  logic  reload,
    input  word_t ao_val,
    output logic  expire
);

    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

    logic  armed;
    logic  ms_step;
    word_t remain;

    always_comb armed = (ao_val != AO_NEVER);

    generate
        if (TICKS_PER_MS > 1) begin : g_pre
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst || reload)
                    pre <= '0;
                else if (en && armed && tick)
                    pre <= (pre == PW'(TICKS_PER_MS - 1)) ? '0 : pre + PW'(1);
            end
            always_comb ms_step = en && armed && tick && (pre == PW'(TICKS_PER_MS - 1));
        end else begin : g_direct
            always_comb ms_step = en && armed && tick;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            remain <= AO_NEVER;
        else if (reload)
            remain <= ao_val;
        else if (ms_step && (remain != '0))
            remain <= remain - word_t'(1);
    end

    always_comb expire = armed && en && (remain == '0) && !reload;

endmodule

// File: rtl/pwm_autooff.sv
module pwm_autooff
    import pwm_ao_pkg::*;
#(
    parameter int TICKS_PER_MS = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       tick,
    output logic       pwm_out
);

    cfg_t  cfg;
    word_t cnt;
    logic  per_load;
    logic  reload;
    logic  expire;

    pwm_ao_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .expire   (expire),
        .cfg      (cfg),
        .per_load (per_load),
        .reload   (reload)
    );

    pwm_ao_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (cfg.en),
        .restart (per_load),
        .period  (cfg.period),
        .duty    (cfg.duty),
        .cnt     (cnt),
        .pwm_out (pwm_out)
    );

    pwm_ao_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .en     (cfg.en),
        .reload (reload),
        .ao_val (cfg.ao),
        .expire (expire)
    );

endmodule

// File: rtl/pwm_autooff_chk.sv
module pwm_autooff_chk
    import pwm_ao_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  pwm_out,
    input cfg_t  cfg,
    input word_t cnt,
    input logic  per_load,
    input logic  expire
);

    // R7
    en_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !pwm_out);

    // R6
    per_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.period == '0) |-> !pwm_out);

    // R6
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.duty == '0) |-> !pwm_out);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        per_load |=> (cnt == '0));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.period != '0) |-> (cnt < cfg.period));

    // R5
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.period != '0 && cfg.duty >= cfg.period) |-> pwm_out);

    // R8
    never_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.ao == AO_NEVER) |-> !expire);

    // R11
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !tick && !per_load) |=> $stable(cnt));

endmodule

bind pwm_autooff pwm_autooff_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pwm_out  (pwm_out),
    .cfg      (cfg),
    .cnt      (cnt),
    .per_load (per_load),
    .expire   (expire)
);

// File: tb/pwm_autooff_tb.sv
module pwm_autooff_tb;

    localparam int TPM = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b1;
    logic       pwm_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    model_on = 1'b0;
    bit    tick_rand = 1'b0;
    string cur_req = "R4";
    bit    done = 1'b0;

    logic        m_en;
    logic [15:0] m_per, m_duty, m_cnt;
    logic [7:0]  m_phs, m_dhs;

    always #2.5 clk = ~clk;

    pwm_autooff #(.TICKS_PER_MS(TPM)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .pwm_out (pwm_out)
    );

    function automatic logic exp_out(input logic e, input logic [15:0] p,
                                     input logic [15:0] d, input logic [15:0] c);
        return e && (p != 16'd0) && (c < d);
    endfunction

    // Bench cycle model of the waveform (auto-off kept at the never code while used)
    always @(posedge clk) begin
        if (rst) begin
            m_en <= 1'b0; m_per <= '0; m_duty <= '0; m_cnt <= '0;
            m_phs <= '0; m_dhs <= '0;
        end else begin
            if (wr_en && wr_addr == 8'hA4) m_cnt <= '0;
            else if (!m_en) m_cnt <= '0;
            else if (tick && m_per != 16'd0)
                m_cnt <= (m_cnt >= m_per - 16'd1) ? 16'd0 : m_cnt + 16'd1;
            if (wr_en) begin
                case (wr_addr)
                    8'hA3: m_en   <= wr_data[0];
                    8'hA4: m_per  <= {m_phs, wr_data};
                    8'hA5: m_phs  <= wr_data;
                    8'hA6: m_duty <= {m_dhs, wr_data};
                    8'hA7: m_dhs  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst)
            check(cur_req, pwm_out, exp_out(m_en, m_per, m_duty, m_cnt));
    end

    always @(negedge clk) begin
        tick <= tick_rand ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst <= 1'b1;
        idle(3);
        rst <= 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run incomplete actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(4);
        rst <= 1'b0;
        idle(1);
        // R1: output low after reset, enable with zero period keeps it low
        check("R1", pwm_out, 1'b0);
        wr(8'hA3, 8'h01);
        idle(3);
        check("R1", pwm_out, 1'b0);
        do_reset();
        model_on = 1'b1;

        // R6: duty zero is low, non-zero duty resumes without enable toggle
        cur_req = "R6";
        wr(8'hA4, 8'd8); wr(8'hA6, 8'd0); wr(8'hA3, 8'h01);
        idle(20);
        wr(8'hA6, 8'd3);
        cur_req = "R4";
        idle(30);
        // R2: staging a new period upper byte does not disturb the waveform
        cur_req = "R2";
        wr(8'hA5, 8'h01);
        idle(30);
        // R3: commit combines staged byte
        cur_req = "R3";
        wr(8'hA5, 8'h00); wr(8'hA4, 8'd5);
        idle(20);
        // R5: duty above period gives constant high
        cur_req = "R5";
        wr(8'hA6, 8'd9);
        idle(20);
        // R10: writes to unused addresses ignored
        cur_req = "R10";
        wr(8'hA0, 8'hFF); wr(8'hA8, 8'h00); wr(8'h00, 8'h00); wr(8'hFF, 8'h00);
        idle(10);
        // R7: disable forces low
        cur_req = "R7";
        wr(8'hA3, 8'h00);
        idle(10);
        wr(8'hA3, 8'h01);
        idle(10);
        // R11: gated tick
        cur_req = "R11";
        wr(8'hA6, 8'd2); wr(8'hA4, 8'd7);
        tick_rand = 1'b1;
        idle(60);

        // Random mix (auto-off stays at the never code)
        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [7:0] d;
            int sel;
            sel = $urandom % 10;
            case (sel)
                0: a = 8'hA3;
                1, 2: a = 8'hA4;
                3: a = 8'hA5;
                4, 5: a = 8'hA6;
                6: a = 8'hA7;
                7: a = 8'h00;
                8: a = 8'hA8;
                default: a = 8'hA0;
            endcase
            if (a == 8'hA5 || a == 8'hA7)
                d = (($urandom % 4) == 0) ? 8'h01 : 8'h00;
            else if (a == 8'hA3)
                d = (($urandom % 5) == 0) ? 8'h00 : 8'h01;
            else
                d = 8'($urandom % 24);
            tick_rand = (($urandom % 2) == 0);
            wr(a, d);
            idle($urandom % 25);
        end
        tick_rand = 1'b0;
        model_on = 1'b0;

        // R8: never code keeps enable set
        do_reset();
        wr(8'hA4, 8'd10); wr(8'hA6, 8'd20); wr(8'hA3, 8'h01);
        idle(300);
        check("R8", pwm_out, 1'b1);

        // R9: countdown of 3 ms clears enable
        wr(8'hA1, 8'h00); wr(8'hA2, 8'h03); wr(8'hA3, 8'h01);
        idle(12);
        check("R9", pwm_out, 1'b1);
        idle(3);
        check("R9", pwm_out, 1'b0);

        // R9: a later write reloads the countdown
        wr(8'hA3, 8'h01);
        idle(7);
        wr(8'hA2, 8'h03);
        idle(11);
        check("R9", pwm_out, 1'b1);
        idle(3);
        check("R9", pwm_out, 1'b0);

        // R9: zero interval clears enable almost at once
        wr(8'hA2, 8'h00); wr(8'hA3, 8'h01);
        idle(3);
        check("R9", pwm_out, 1'b0);

        // R8: back to never code, long run stays high
        wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF); wr(8'hA3, 8'h01);
        idle(200);
        check("R8", pwm_out, 1'b1);

        // R1: reset restores never code and clears output
        do_reset();
        check("R1", pwm_out, 1'b0);
        wr(8'hA4, 8'd4); wr(8'hA6, 8'd8); wr(8'hA3, 8'h01);
        idle(200);
        check("R1", pwm_out, 1'b1);

        finish_run();
    end

endmodule